// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register File

This block holds the configuration state of an interrupt redirection controller. Software reaches it through two locations on a simple memory-mapped bus. The first is an 8-bit index register. The second is a 32-bit data window that reads or writes whichever internal register the index names. Behind the window are a version word, a 4-bit identifier, an arbitration word that mirrors the identifier, and one 64-bit redirection entry per input pin. Each entry is split across two consecutive indices.

Delivery logic sits next to this block. It sees every entry at once on a flat output bus and uses a per-pin input to set each entry's remote-request status bit. It also receives a one-cycle strobe, with the entry number, after any table write, so it can re-evaluate pending requests. A write to the low half of an entry clears that entry's status bit. Byte, halfword and word writes are accepted. Narrow writes are zero-extended to 32 bits before use.

Top module: `irq_route_regs`

## Requirements
- R1: Offset 0x00 is the index register. A write stores only bits 7:0 of the zero-extended data, and a read returns the index in bits 7:0 with bits 31:8 zero.
- R2: Index 0x01 reads {8'h00, NUM_PINS-1, 8'h00, VERSION}. Writes to it change nothing.
- R3: Index 0x00 holds a 4-bit identifier in window bits 27:24, and all other bits read zero. Index 0x02 reads the same word. Writes through index 0x02 change nothing.
- R4: For an index s of 0x10 or above, the entry number is (s-0x10)>>1. An even s maps to entry bits 31:0 and an odd s maps to entry bits 63:32. Reads and writes through offset 0x10 use this mapping.
- R5: Indices 0x03 to 0x0F, and entry numbers at or above NUM_PINS, read 32'hFFFFFFFF. Writes to them change no state and raise no strobe.
- R6: Entry bit 14 is the remote-request status bit. A low-half write always stores 0 there, whatever the data says. A high-half write leaves it unchanged.
- R7: A one-cycle pulse on irrSet[n] sets bit 14 of entry n. If a low-half write to entry n happens in the same cycle, the write wins and the bit ends at 0. Other entries still take their pulses.
- R8: After reset, every entry equals 64'h0000_0000_0001_0000 (only the mask bit, bit 16, is set), the index is 0 and the identifier is 0.
- R9: busSize 0 selects a byte write and busSize 1 a halfword write. The low 8 or 16 bits of busWdata are zero-extended to 32 bits before the write. busSize 2 writes the full word.
- R10: Any bus offset other than 0x00 and 0x10 reads 0 and ignores writes.
- R11: After each table write, entryWritten is high for exactly one cycle, the cycle that follows the write edge, with entryWrittenIdx holding the entry number.
- R12: tableFlat[64n+63:64n] always equals entry n, and it updates on the same edge as the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset within the block |
| busSize | input | 2 | 0 byte, 1 halfword, 2 word |
| busWdata | input | 32 | Write data, low lanes used for narrow writes |
| busRdata | output | 32 | Read data, combinational, valid while busSel and !busWr |
| irrSet | input | NUM_PINS | Per-entry set pulse for the remote-request bit |
| tableFlat | output | NUM_PINS*64 | All entries, entry n at bits 64n+63:64n |
| entryWritten | output | 1 | One-cycle pulse after a table write |
| entryWrittenIdx | output | $clog2(NUM_PINS) | Entry number of the last table write |

## Verification
Two things can land on the same entry in the same cycle: a set pulse from the delivery side and a low-half bus write. To provoke this, the bench raises irrSet for the entry being written, and for a neighbouring entry, in the very cycle the window write is presented. It then judges the result by reading the status bit back through the window and on tableFlat. The written entry must show 0 and the neighbour must show 1. Separately, every index value from 0x00 to 0xFF is swept, and each readback is compared with a value the bench computes from the index arithmetic.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam logic [7:0] OFS_INDEX  = 8'h00;
  localparam logic [7:0] OFS_WINDOW = 8'h10;

  localparam logic [7:0] IDX_IDENT  = 8'h00;
  localparam logic [7:0] IDX_VER    = 8'h01;
  localparam logic [7:0] IDX_ARB    = 8'h02;
  localparam logic [7:0] IDX_TABLE  = 8'h10;

  localparam int BIT_REMOTE = 14;
  localparam int BIT_MASK   = 16;
  localparam logic [63:0] ENTRY_RESET = 64'h0000_0000_0001_0000;

  typedef struct packed {
    logic idxWr;
    logic identWr;
    logic entLoWr;
    logic entHiWr;
    logic entHit;
    logic idxRd;
    logic winRd;
  } winCtl_t;
endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int IW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busSel,
  input  logic          busWr,
  input  logic [7:0]    busAddr,
  input  logic [1:0]    busSize,
  input  logic [31:0]   busWdata,
  input  logic [7:0]    idxReg,
  output winCtl_t       ctl,
  output logic [IW-1:0] entIdx,
  output logic [31:0]   wrData
);
  logic [7:0] entOff;
  logic [6:0] entNum;
  logic       wrAcc;
  logic       rdAcc;

  assign entOff = idxReg - IDX_TABLE;
  assign entNum = entOff[7:1];
  assign entIdx = entNum[IW-1:0];
  assign wrAcc  = busSel && busWr;
  assign rdAcc  = busSel && !busWr;

  always_comb begin
    unique case (busSize)
      2'd0:    wrData = {24'h0, busWdata[7:0]};
      2'd1:    wrData = {16'h0, busWdata[15:0]};
      default: wrData = busWdata;
    endcase
  end

  always_comb begin
    ctl         = '0;
    ctl.entHit  = (idxReg >= IDX_TABLE) && (entNum < 7'(NUM_PINS));
    ctl.idxWr   = wrAcc && (busAddr == OFS_INDEX);
    ctl.identWr = wrAcc && (busAddr == OFS_WINDOW) && (idxReg == IDX_IDENT);
    ctl.entLoWr = wrAcc && (busAddr == OFS_WINDOW) && ctl.entHit && !idxReg[0];
    ctl.entHiWr = wrAcc && (busAddr == OFS_WINDOW) && ctl.entHit && idxReg[0];
    ctl.idxRd   = rdAcc && (busAddr == OFS_INDEX);
    ctl.winRd   = rdAcc && (busAddr == OFS_WINDOW);
  end

  // R10
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.idxWr, ctl.identWr, ctl.entLoWr, ctl.entHiWr}));
endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter logic [7:0] VERSION = 8'h11,
  localparam int IW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  winCtl_t                ctl,
  input  logic [IW-1:0]          entIdx,
  input  logic [31:0]            wrData,
  input  logic [NUM_PINS-1:0]    irrSet,
  output logic [7:0]             idxReg,
  output logic [31:0]            busRdata,
  output logic [NUM_PINS*64-1:0] tableFlat,
  output logic                   entryWritten,
  output logic [IW-1:0]          entryWrittenIdx
);
  localparam logic [7:0] TOP_PIN = 8'(NUM_PINS - 1);

  logic [3:0]                 identReg;
  logic [NUM_PINS-1:0][63:0]  tblArr;
  logic [31:0]                winData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxReg          <= '0;
      identReg        <= '0;
      entryWritten    <= 1'b0;
      entryWrittenIdx <= '0;
    end else begin
      if (ctl.idxWr)   idxReg   <= wrData[7:0];
      if (ctl.identWr) identReg <= wrData[27:24];
      entryWritten <= ctl.entLoWr || ctl.entHiWr;
      if (ctl.entLoWr || ctl.entHiWr) entryWrittenIdx <= entIdx;
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : gEntry
    logic [63:0] ent;
    logic        hitG;
    assign hitG = (entIdx == IW'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ent <= ENTRY_RESET;
      end else begin
        if (ctl.entLoWr && hitG)
          ent[31:0] <= {wrData[31:BIT_REMOTE+1], 1'b0, wrData[BIT_REMOTE-1:0]};
        else if (irrSet[g])
          ent[BIT_REMOTE] <= 1'b1;
        if (ctl.entHiWr && hitG)
          ent[63:32] <= wrData;
      end
    end
    assign tblArr[g] = ent;
  end

  assign tableFlat = tblArr;

  always_comb begin
    unique case (idxReg)
      IDX_IDENT, IDX_ARB: winData = {4'h0, identReg, 24'h0};
      IDX_VER:            winData = {8'h0, TOP_PIN, 8'h0, VERSION};
      default: begin
        if (ctl.entHit)
          winData = idxReg[0] ? tblArr[entIdx][63:32] : tblArr[entIdx][31:0];
        else
          winData = '1;
      end
    endcase
  end

  always_comb begin
    if (ctl.idxRd)      busRdata = {24'h0, idxReg};
    else if (ctl.winRd) busRdata = winData;
    else                busRdata = '0;
  end

  // R6
  low_clears_remote_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.entLoWr |=> tblArr[$past(entIdx)][BIT_REMOTE] == 1'b0);

  // R4
  high_half_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.entHiWr |=> tblArr[$past(entIdx)][63:32] == $past(wrData));

  // R1
  index_low_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.idxWr |=> idxReg == $past(wrData[7:0]));

  // R3
  ident_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.identWr |=> $stable(identReg));

  // R11
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (entryWritten && !$past(ctl.entLoWr || ctl.entHiWr)) == 1'b0);
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter logic [7:0] VERSION = 8'h11,
  localparam int IW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busSel,
  input  logic                   busWr,
  input  logic [7:0]             busAddr,
  input  logic [1:0]             busSize,
  input  logic [31:0]            busWdata,
  output logic [31:0]            busRdata,
  input  logic [NUM_PINS-1:0]    irrSet,
  output logic [NUM_PINS*64-1:0] tableFlat,
  output logic                   entryWritten,
  output logic [IW-1:0]          entryWrittenIdx
);
  winCtl_t       ctl;
  logic [IW-1:0] entIdx;
  logic [31:0]   wrData;
  logic [7:0]    idxReg;

  irq_route_ctrl #(.NUM_PINS(NUM_PINS)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .idxReg(idxReg), .ctl(ctl), .entIdx(entIdx), .wrData(wrData)
  );

  irq_route_dp #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .entIdx(entIdx), .wrData(wrData),
    .irrSet(irrSet), .idxReg(idxReg), .busRdata(busRdata),
    .tableFlat(tableFlat), .entryWritten(entryWritten),
    .entryWrittenIdx(entryWrittenIdx)
  );
endmodule

// File: tb/irq_route_regs_test.sv
module irq_route_regs_test;
  localparam int NP = 24;
  localparam int IW = $clog2(NP);
  localparam logic [7:0] VER = 8'h11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [7:0] busAddr = '0;
  logic [1:0] busSize = 2'd2;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NP-1:0] irrSet = '0;
  logic [NP*64-1:0] tableFlat;
  logic entryWritten;
  logic [IW-1:0] entryWrittenIdx;

  int total = 0, fails = 0, cyc = 0;
  logic [63:0] model [NP];
  logic [3:0]  mIdent = '0;

  always #5 clk = ~clk;

  irq_route_regs #(.NUM_PINS(NP), .VERSION(VER)) uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busSize(busSize), .busWdata(busWdata), .busRdata(busRdata), .irrSet(irrSet),
    .tableFlat(tableFlat), .entryWritten(entryWritten), .entryWrittenIdx(entryWrittenIdx)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busSize = sz; busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] r);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = a;
    #1 r = busRdata;
    busSel = 0;
  endtask

  function automatic logic [31:0] expWin(input int s);
    int n;
    if (s == 0 || s == 2) return {4'h0, mIdent, 24'h0};
    if (s == 1) return {8'h0, 8'(NP - 1), 8'h0, VER};
    n = (s - 16) >>> 1;
    if (s >= 16 && n < NP) return (s % 2 == 1) ? model[n][63:32] : model[n][31:0];
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic tableMatches();
    for (int n = 0; n < NP; n++)
      if (tableFlat[64*n +: 64] !== model[n]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic entWrite(input int n, input logic hi, input logic [31:0] d);
    wr(8'h00, 2'd2, 32'(16 + 2*n + (hi ? 1 : 0)));
    wr(8'h10, 2'd2, d);
    if (hi) model[n][63:32] = d;
    else    model[n][31:0]  = {d[31:15], 1'b0, d[13:0]};
    chk("R11 strobe", {63'h0, entryWritten}, 64'h1);
    chk("R11 index", 64'(entryWrittenIdx), 64'(n));
    chk("R12 flat", tableFlat[64*n +: 64], model[n]);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; total++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    for (int n = 0; n < NP; n++) model[n] = 64'h0000_0000_0001_0000;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R8 reset state
    chk("R8 table", {63'h0, tableMatches()}, 64'h1);
    rd(8'h00, r); chk("R8 index", 64'(r), 64'h0);
    rd(8'h10, r); chk("R8 ident", 64'(r), 64'h0);

    // R4 R12 R11: fill every entry, both halves
    for (int n = 0; n < NP; n++) begin
      entWrite(n, 1'b0, 32'h5A5A_C000 ^ (32'(n) * 32'h0001_0123));
      entWrite(n, 1'b1, 32'hC300_00F0 ^ (32'(n) << 24) ^ 32'(n));
      @(negedge clk);
      chk("R11 single pulse", {63'h0, entryWritten}, 64'h0);
    end
    chk("R12 all", {63'h0, tableMatches()}, 64'h1);

    // R3 identifier and arbitration mirror
    wr(8'h00, 2'd2, 32'h0); wr(8'h10, 2'd2, 32'hFBCD_EF12); mIdent = 4'hB;
    wr(8'h00, 2'd2, 32'h2); wr(8'h10, 2'd2, 32'h0700_0000);
    rd(8'h10, r); chk("R3 arb mirror, write ignored", 64'(r), 64'(expWin(2)));
    // R2 version write ignored
    wr(8'h00, 2'd2, 32'h1); wr(8'h10, 2'd2, 32'h0000_0000);
    rd(8'h10, r); chk("R2 version", 64'(r), 64'h0017_0011);

    // R5 out-of-range writes
    wr(8'h00, 2'd2, 32'h40); wr(8'h10, 2'd2, 32'h1234_5678);
    chk("R5 no strobe", {63'h0, entryWritten}, 64'h0);
    wr(8'h00, 2'd2, 32'h07); wr(8'h10, 2'd2, 32'h1234_5678);
    chk("R5 table kept", {63'h0, tableMatches()}, 64'h1);

    // R10 other offsets
    wr(8'h04, 2'd2, 32'hFFFF_FFFF);
    wr(8'h14, 2'd2, 32'h0000_0000);
    rd(8'h04, r); chk("R10 read zero", 64'(r), 64'h0);
    rd(8'h00, r); chk("R10 index kept", 64'(r), 64'h07);
    chk("R10 table kept", {63'h0, tableMatches()}, 64'h1);

    // R1 R5 R2 R3 R4: sweep every index value
    for (int s = 0; s < 256; s++) begin
      wr(8'h00, 2'd2, 32'hABCD_EF00 | 32'(s));
      rd(8'h00, r); chk("R1 index low byte", 64'(r), 64'(s));
      rd(8'h10, r); chk("R4 R5 window sweep", 64'(r), 64'(expWin(s)));
    end

    // R9 narrow writes
    wr(8'h00, 2'd0, 32'hFFFF_FF16);
    rd(8'h00, r); chk("R9 byte index", 64'(r), 64'h16);
    wr(8'h10, 2'd1, 32'hDEAD_BEEF); model[3][31:0] = 32'h0000_BEEF & ~32'h4000;
    chk("R9 halfword", tableFlat[64*3 +: 64], model[3]);
    wr(8'h17 - 8'h00, 2'd0, 32'h0); // offset 0x17 is not a register
    wr(8'h00, 2'd0, 32'h17); wr(8'h10, 2'd0, 32'h1234_56C3); model[3][63:32] = 32'hC3;
    rd(8'h10, r); chk("R9 byte high", 64'(r), 64'hC3);

    // R7 R6 remote bit set, kept by high write, cleared by low write
    @(negedge clk); irrSet[4] = 1; @(negedge clk); irrSet = '0; model[4][14] = 1;
    chk("R7 set", tableFlat[64*4 +: 64], model[4]);
    entWrite(4, 1'b1, 32'h0102_0304);
    chk("R6 high keeps", {63'h0, tableFlat[64*4 + 14]}, 64'h1);
    entWrite(4, 1'b0, 32'hFFFF_FFFF);
    chk("R6 low clears", {63'h0, tableFlat[64*4 + 14]}, 64'h0);

    // R7 same-cycle collision: write entry 5 low, pulse entries 5 and 6
    wr(8'h00, 2'd2, 32'(16 + 10));
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = 8'h10; busSize = 2'd2; busWdata = 32'h0000_4055;
    irrSet[5] = 1; irrSet[6] = 1;
    @(negedge clk);
    busSel = 0; busWr = 0; irrSet = '0;
    model[5][31:0] = 32'h0000_0055; model[6][14] = 1;
    rd(8'h10, r); chk("R7 write wins", 64'(r), 64'h55);
    chk("R7 neighbour set", tableFlat[64*6 +: 64], model[6]);
    chk("R12 final", {63'h0, tableMatches()}, 64'h1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule